// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block is the device-side read path of a parallel flash while an internal program or erase runs. A host reads through a one-cycle read strobe with an address. When no operation is running, the byte returned is the stored array content. When an operation is running, or has failed, the byte returned is a status word. The status word has a completion-polling bit, a bit that flips on every read, a failure flag and an erase-kind flag.

The command decoder is reduced to four one-cycle pulses: program one byte, erase one sector, erase the whole chip, and reset. A per-sector protection mask is an input. A small register array stands in for the flash cells. Each operation is timed by a cycle counter.

Programming can only clear bits. An erase sets every byte of the affected sectors to 0xFF. An operation that targets only protected storage runs out a longer timeout and leaves the data unchanged. A program that would need to turn a 0 back into a 1 stalls until the pulse limit expires. It then reports a failure that only a reset clears.

Top module: `flash_status_gen`

## Requirements
- R1: After reset every array byte is 0xFF and `rd_data` is 0x00. When no operation is running, a read sampled at a clock edge returns the byte at `rd_addr` on `rd_data` after that edge. `rd_data` holds its value when `rd_en` is low.
- R2: A status read is any read taken while an operation runs or after a failure. On consecutive status reads, bit 6 of `rd_data` has opposite values.
- R3: Status word layout. Bit 7 is the inverse of bit 7 of the program data during a program, and 0 during an erase. Bit 5 is the failure flag. Bit 3 is 1 only during a sector erase. Bits 4, 2, 1 and 0 are 0.
- R4: A command pulse is taken at clock edge E0. For a program into an unprotected sector, reads sampled at edges E1..E(PROG_CYC) return status. The read at E(PROG_CYC+1) returns the new byte, which is old AND data.
- R5: A program into a protected sector returns status for PROT_PROG_CYC edges. After that the target byte is unchanged.
- R6: A sector erase of an unprotected sector returns status for ERASE_CYC edges. It then sets every byte of that sector to 0xFF and leaves the other sectors untouched. The sector index is the top SECT_W address bits.
- R7: A sector erase of a protected sector returns status for PROT_ERASE_CYC edges and changes no data.
- R8: A chip erase returns status with bit 3 at 0. If any sector is unprotected, it lasts ERASE_CYC edges and erases only the unprotected sectors. If all sectors are protected, it lasts PROT_ERASE_CYC edges and changes nothing.
- R9: A program whose data has a 1 where the stored byte has a 0 returns status with bit 5 at 0 for LIMIT_CYC edges. After that, status reads carry bit 5 at 1 and bit 6 keeps flipping. The array is not changed.
- R10: In the failed state only a reset pulse returns the block to array reads, and any other command is ignored there. While an operation is running, every command, including reset, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe, one read per cycle high |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Array byte or status word |
| cmd_prog | input | 1 | Start a byte program |
| cmd_sect_erase | input | 1 | Start a sector erase |
| cmd_chip_erase | input | 1 | Start a chip erase |
| cmd_reset | input | 1 | Leave the failed state |
| cmd_addr | input | ADDR_W | Target address of program or sector erase |
| cmd_data | input | 8 | Program data |
| prot_mask | input | 2**SECT_W | Per-sector protection, 1 = protected |

## Verification
The bench reads on every cycle after each command and checks the edge at which status gives way to data, for every duration. A counter that is off by one would put data one read early or late. The failure case checks three things: that bit 5 is not set before the limit, that it stays set with bit 6 still flipping, and that it survives a stray program command. A design that cleared it early, or let the command through, would be reported. The bench also sends reset and erase pulses during a running program. It checks chip erase against a mixed protection mask, and the sectors next to an erased one. A design that aborted the program, erased protected sectors or erased too wide a range would return the wrong bytes.

// File: rtl/flash_status_pkg.sv
`timescale 1ns/1ps
// Shared types for the flash status generator.
package flash_status_pkg;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_BUSY = 2'd1, ST_FAIL = 2'd2} op_state_t;
    typedef enum logic [1:0] {OP_PROG = 2'd0, OP_SERASE = 2'd1, OP_CERASE = 2'd2} op_kind_t;
endpackage

// File: rtl/fsg_array.sv
`timescale 1ns/1ps
// Register array standing in for the flash cells.
// Has two combinational read ports: one for the host, one for the sequencer's pre-check.
// A program ANDs data into one byte. An erase sets all bytes of the masked sectors to 0xFF.
// Assumes program and erase never occur in the same cycle.
module fsg_array #(
    parameter int ADDR_W = 6,
    parameter int SECT_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [7:0]           rd_byte,
    input  logic [ADDR_W-1:0]    chk_addr,
    output logic [7:0]           chk_byte,
    input  logic                 pgm_en,
    input  logic [ADDR_W-1:0]    pgm_addr,
    input  logic [7:0]           pgm_data,
    input  logic                 erase_en,
    input  logic [2**SECT_W-1:0] erase_mask
);
    localparam int DEPTH  = 2**ADDR_W;
    localparam int SECT_SH = ADDR_W - SECT_W;

    logic [7:0] mem [DEPTH];

    assign rd_byte  = mem[rd_addr];
    assign chk_byte = mem[chk_addr];

    // Update cells: reset to erased, clear bits on program, set sectors on erase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (erase_en) begin
            for (int i = 0; i < DEPTH; i++)
                if (erase_mask[i >> SECT_SH]) mem[i] <= 8'hFF;
        end else if (pgm_en) begin
            mem[pgm_addr] <= mem[pgm_addr] & pgm_data;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cell_chk
            // R4
            no_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !erase_en |=> ((mem[g] & ~$past(mem[g])) == 8'h00));
        end
    endgenerate
endmodule

// File: rtl/fsg_sequencer.sv
`timescale 1ns/1ps
// Operation sequencer. Accepts command pulses in idle and picks each operation's duration.
// The duration depends on protection, and on whether a program is possible at all.
// Counts the operation down and fires the array write on its last cycle.
// Enters the failed state when an impossible program runs out.
// Assumes command pulses last one cycle. Priority is chip erase, then sector erase, then program.
module fsg_sequencer
    import flash_status_pkg::*;
#(
    parameter int ADDR_W         = 6,
    parameter int SECT_W         = 2,
    parameter int PROG_CYC       = 6,
    parameter int PROT_PROG_CYC  = 10,
    parameter int ERASE_CYC      = 20,
    parameter int PROT_ERASE_CYC = 40,
    parameter int LIMIT_CYC      = 30
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_prog,
    input  logic                 cmd_sect_erase,
    input  logic                 cmd_chip_erase,
    input  logic                 cmd_reset,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [7:0]           cmd_data,
    input  logic [2**SECT_W-1:0] prot_mask,
    input  logic [7:0]           old_byte,
    output op_state_t            st,
    output op_kind_t             kind,
    output logic [7:0]           op_data,
    output logic                 pgm_en,
    output logic [ADDR_W-1:0]    pgm_addr,
    output logic                 erase_en,
    output logic [2**SECT_W-1:0] erase_mask
);
    localparam int NSECT = 2**SECT_W;
    localparam int MAX1  = (PROG_CYC > PROT_PROG_CYC) ? PROG_CYC : PROT_PROG_CYC;
    localparam int MAX2  = (ERASE_CYC > PROT_ERASE_CYC) ? ERASE_CYC : PROT_ERASE_CYC;
    localparam int MAX3  = (MAX1 > MAX2) ? MAX1 : MAX2;
    localparam int MAXC  = (MAX3 > LIMIT_CYC) ? MAX3 : LIMIT_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] L_PROG   = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] L_PPROG  = CNT_W'(PROT_PROG_CYC - 1);
    localparam logic [CNT_W-1:0] L_ERASE  = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] L_PERASE = CNT_W'(PROT_ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] L_LIMIT  = CNT_W'(LIMIT_CYC - 1);

    logic [CNT_W-1:0]  cnt;
    logic              does_write;
    logic              doomed;
    logic [NSECT-1:0]  emask_q;
    logic [SECT_W-1:0] csect;
    logic [NSECT-1:0]  unprot;
    logic              last_cyc;

    assign csect    = cmd_addr[ADDR_W-1 -: SECT_W];
    assign unprot   = ~prot_mask;
    assign last_cyc = (st == ST_BUSY) && (cnt == '0);

    // Accept commands, run the countdown and move between idle, busy and failed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            kind       <= OP_PROG;
            cnt        <= '0;
            op_data    <= 8'h00;
            pgm_addr   <= '0;
            does_write <= 1'b0;
            doomed     <= 1'b0;
            emask_q    <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (cmd_chip_erase) begin
                        st         <= ST_BUSY;
                        kind       <= OP_CERASE;
                        emask_q    <= unprot;
                        does_write <= |unprot;
                        doomed     <= 1'b0;
                        cnt        <= (|unprot) ? L_ERASE : L_PERASE;
                    end else if (cmd_sect_erase) begin
                        st         <= ST_BUSY;
                        kind       <= OP_SERASE;
                        emask_q    <= NSECT'(1) << csect;
                        does_write <= !prot_mask[csect];
                        doomed     <= 1'b0;
                        cnt        <= prot_mask[csect] ? L_PERASE : L_ERASE;
                    end else if (cmd_prog) begin
                        st       <= ST_BUSY;
                        kind     <= OP_PROG;
                        op_data  <= cmd_data;
                        pgm_addr <= cmd_addr;
                        if (prot_mask[csect]) begin
                            does_write <= 1'b0;
                            doomed     <= 1'b0;
                            cnt        <= L_PPROG;
                        end else if ((cmd_data & ~old_byte) != 8'h00) begin
                            does_write <= 1'b0;
                            doomed     <= 1'b1;
                            cnt        <= L_LIMIT;
                        end else begin
                            does_write <= 1'b1;
                            doomed     <= 1'b0;
                            cnt        <= L_PROG;
                        end
                    end
                end
                ST_BUSY: begin
                    if (cnt == '0) st <= doomed ? ST_FAIL : ST_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                ST_FAIL: begin
                    if (cmd_reset) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign pgm_en     = last_cyc && does_write && (kind == OP_PROG);
    assign erase_en   = last_cyc && does_write && (kind != OP_PROG);
    assign erase_mask = emask_q;

    // R10
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FAIL && !cmd_reset) |=> st == ST_FAIL);
    // R10
    busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && cnt != '0) |=> (st == ST_BUSY && $stable(kind)));
    // R9
    fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        doomed |-> !(pgm_en || erase_en));
endmodule

// File: rtl/fsg_status.sv
`timescale 1ns/1ps
// Read-out stage. Registers either the array byte or the status word on each read strobe.
// Flips the toggle flag on every status read.
// Assumes the state and operation kind come from the sequencer.
module fsg_status
    import flash_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  op_state_t  st,
    input  op_kind_t   kind,
    input  logic [7:0] op_data,
    input  logic [7:0] array_byte,
    output logic [7:0] rd_data
);
    logic       tgl;
    logic       poll_bit;
    logic [7:0] status_word;
    logic       status_rd;

    assign poll_bit    = (kind == OP_PROG) ? ~op_data[7] : 1'b0;
    assign status_word = {poll_bit, tgl, (st == ST_FAIL), 1'b0,
                          (kind == OP_SERASE), 3'b000};
    assign status_rd   = rd_en && (st != ST_IDLE);

    // Capture the read result and advance the toggle flag on status reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= 8'h00;
            tgl     <= 1'b0;
        end else if (rd_en) begin
            if (st == ST_IDLE) begin
                rd_data <= array_byte;
            end else begin
                rd_data <= status_word;
                tgl     <= ~tgl;
            end
        end
    end

    // R2
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && $past(status_rd)) |=> rd_data[6] != $past(rd_data[6]));
    // R9
    no_early_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st == ST_BUSY) |=> !rd_data[5]);
    // R3
    erase_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st == ST_BUSY && kind == OP_SERASE) |=> (rd_data[3] && !rd_data[7]));
    // R3
    zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd |=> (rd_data[4] == 1'b0 && rd_data[2:0] == 3'b000));
    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/flash_status_gen.sv
`timescale 1ns/1ps
// Top of the flash status generator. Connects the sequencer, the register array
// and the read-out stage. Assumes synchronous single-clock use.
module flash_status_gen
    import flash_status_pkg::*;
#(
    parameter int ADDR_W         = 6,
    parameter int SECT_W         = 2,
    parameter int PROG_CYC       = 6,
    parameter int PROT_PROG_CYC  = 10,
    parameter int ERASE_CYC      = 20,
    parameter int PROT_ERASE_CYC = 40,
    parameter int LIMIT_CYC      = 30
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [7:0]           rd_data,
    input  logic                 cmd_prog,
    input  logic                 cmd_sect_erase,
    input  logic                 cmd_chip_erase,
    input  logic                 cmd_reset,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [7:0]           cmd_data,
    input  logic [2**SECT_W-1:0] prot_mask
);
    localparam int NSECT = 2**SECT_W;

    op_state_t         st;
    op_kind_t          kind;
    logic [7:0]        op_data;
    logic [7:0]        old_byte;
    logic [7:0]        array_byte;
    logic              pgm_en;
    logic [ADDR_W-1:0] pgm_addr;
    logic              erase_en;
    logic [NSECT-1:0]  erase_mask;

    fsg_sequencer #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC),
        .PROT_PROG_CYC(PROT_PROG_CYC), .ERASE_CYC(ERASE_CYC),
        .PROT_ERASE_CYC(PROT_ERASE_CYC), .LIMIT_CYC(LIMIT_CYC)
    ) i_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_prog(cmd_prog), .cmd_sect_erase(cmd_sect_erase),
        .cmd_chip_erase(cmd_chip_erase), .cmd_reset(cmd_reset),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .prot_mask(prot_mask),
        .old_byte(old_byte), .st(st), .kind(kind), .op_data(op_data),
        .pgm_en(pgm_en), .pgm_addr(pgm_addr),
        .erase_en(erase_en), .erase_mask(erase_mask)
    );

    fsg_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_arr (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(rd_addr), .rd_byte(array_byte),
        .chk_addr(cmd_addr), .chk_byte(old_byte),
        .pgm_en(pgm_en), .pgm_addr(pgm_addr), .pgm_data(op_data),
        .erase_en(erase_en), .erase_mask(erase_mask)
    );

    fsg_status i_stat (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
        .st(st), .kind(kind), .op_data(op_data),
        .array_byte(array_byte), .rd_data(rd_data)
    );
endmodule

// File: tb/test_flash_status_gen.sv
`timescale 1ns/1ps
// Directed bench for flash_status_gen, one task per scenario.
module test_flash_status_gen;
    localparam int AW = 6;
    localparam int PC = 6, PPC = 10, EC = 20, PEC = 40, LC = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          cmd_prog = 1'b0, cmd_sect_erase = 1'b0, cmd_chip_erase = 1'b0, cmd_reset = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_data = 8'h00;
    logic [3:0]    prot_mask = 4'b0000;

    int  vectors = 0;
    int  fails = 0;
    bit  done = 1'b0;
    logic [7:0] prev_st;
    bit  have_prev;

    flash_status_gen #(.ADDR_W(AW), .SECT_W(2), .PROG_CYC(PC), .PROT_PROG_CYC(PPC),
        .ERASE_CYC(EC), .PROT_ERASE_CYC(PEC), .LIMIT_CYC(LC)) i_flash_status_gen (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .cmd_prog(cmd_prog), .cmd_sect_erase(cmd_sect_erase), .cmd_chip_erase(cmd_chip_erase),
        .cmd_reset(cmd_reset), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .prot_mask(prot_mask));

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0; v = rd_data;
    endtask

    // kind: 0 program, 1 sector erase, 2 chip erase, 3 reset
    task automatic pulse(input int k, input logic [AW-1:0] a, input logic [7:0] d);
        cmd_addr = a; cmd_data = d;
        case (k)
            0: cmd_prog = 1'b1;
            1: cmd_sect_erase = 1'b1;
            2: cmd_chip_erase = 1'b1;
            default: cmd_reset = 1'b1;
        endcase
        @(negedge clk);
        cmd_prog = 1'b0; cmd_sect_erase = 1'b0; cmd_chip_erase = 1'b0; cmd_reset = 1'b0;
        have_prev = 1'b0;
    endtask

    // One status read: checks the fixed bits and that bit 6 flipped (R2, R3).
    task automatic st_read(input string tag, input logic [7:0] exp);
        logic [7:0] v;
        rd(6'd0, v);
        chk({tag, " status"}, v & 8'hBF, exp);
        if (have_prev) chk("R2 toggle", v[6] ^ prev_st[6], 8'h01 & 8'h01 ? 8'h01 : 8'h00);
        prev_st = v; have_prev = 1'b1;
    endtask

    task automatic st_reads(input string tag, input int n, input logic [7:0] exp);
        for (int i = 0; i < n; i++) st_read(tag, exp);
    endtask

    task automatic expect_byte(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic t_reset_state;
        chk("R1 rd_data after reset", rd_data, 8'h00);
        expect_byte("R1 erased byte", 6'd0, 8'hFF);
        expect_byte("R1 erased byte", 6'd63, 8'hFF);
    endtask

    task automatic t_program;
        pulse(0, 6'd5, 8'hA5);
        st_reads("R4 program A5", PC, 8'h00);
        expect_byte("R4 program done at boundary", 6'd5, 8'hA5);
        pulse(0, 6'd6, 8'h3C);
        st_reads("R3 poll bit inverted", PC, 8'h80);
        expect_byte("R4 program 3C", 6'd6, 8'h3C);
        pulse(0, 6'd17, 8'h22);
        st_reads("R4 program 22", PC, 8'h80);
        expect_byte("R4 program 22", 6'd17, 8'h22);
        pulse(0, 6'd40, 8'h11);
        st_reads("R4 program 11", PC, 8'h80);
        expect_byte("R4 program 11", 6'd40, 8'h11);
        pulse(0, 6'd40, 8'h01);
        st_reads("R4 program AND", PC, 8'h80);
        expect_byte("R4 program AND result", 6'd40, 8'h01);
    endtask

    task automatic t_fail;
        pulse(0, 6'd5, 8'hFF);
        st_reads("R9 before limit", LC, 8'h00);
        st_reads("R9 failed flag", 3, 8'h20);
        pulse(0, 6'd20, 8'h00);
        st_reads("R10 command ignored in failure", 3, 8'h20);
        pulse(3, 6'd0, 8'h00);
        expect_byte("R10 reset leaves failure", 6'd5, 8'hA5);
        expect_byte("R10 ignored program", 6'd20, 8'hFF);
    endtask

    task automatic t_prot_prog;
        prot_mask = 4'b0010;
        pulse(0, 6'd17, 8'h00);
        st_reads("R5 protected program", PPC, 8'h80);
        expect_byte("R5 protected byte kept", 6'd17, 8'h22);
        prot_mask = 4'b0000;
    endtask

    task automatic t_busy_ignore;
        pulse(0, 6'd33, 8'h5A);
        st_read("R10 busy", 8'h80);
        cmd_reset = 1'b1;
        st_read("R10 reset during run", 8'h80);
        cmd_reset = 1'b0; cmd_chip_erase = 1'b1;
        st_read("R10 erase during run", 8'h80);
        cmd_chip_erase = 1'b0;
        st_reads("R10 busy", PC - 3, 8'h80);
        expect_byte("R10 program finished", 6'd33, 8'h5A);
        expect_byte("R10 no erase happened", 6'd40, 8'h01);
    endtask

    task automatic t_sect_erase;
        pulse(1, 6'd0, 8'h00);
        st_reads("R6 sector erase", EC, 8'h08);
        expect_byte("R6 erased", 6'd5, 8'hFF);
        expect_byte("R6 erased", 6'd6, 8'hFF);
        expect_byte("R6 neighbour kept", 6'd17, 8'h22);
        expect_byte("R6 far sector kept", 6'd40, 8'h01);
    endtask

    task automatic t_prot_sect;
        prot_mask = 4'b0010;
        pulse(1, 6'd16, 8'h00);
        st_reads("R7 protected sector erase", PEC, 8'h08);
        expect_byte("R7 data kept", 6'd17, 8'h22);
    endtask

    task automatic t_chip;
        prot_mask = 4'b0010;
        pulse(2, 6'd0, 8'h00);
        st_reads("R8 chip erase", EC, 8'h00);
        expect_byte("R8 unprotected erased", 6'd40, 8'hFF);
        expect_byte("R8 unprotected erased", 6'd33, 8'hFF);
        expect_byte("R8 protected kept", 6'd17, 8'h22);
        prot_mask = 4'b1111;
        pulse(2, 6'd0, 8'h00);
        st_reads("R8 all protected", PEC, 8'h00);
        expect_byte("R8 all protected kept", 6'd17, 8'h22);
        prot_mask = 4'b0000;
    endtask

    initial begin
        have_prev = 1'b0;
        prev_st = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state;
        t_program;
        t_fail;
        t_prot_prog;
        t_busy_ignore;
        t_sect_erase;
        t_prot_sect;
        t_chip;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule